// File: doc/BRIEF.md
# DRAM Geometry Probe Engine

This block discovers the geometry of an attached memory device at bring-up time: how many column address bits it decodes, how many row address bits, and whether one or two ranks answer. It does so without any configuration table. Each candidate geometry is tested by a short aliasing experiment over a simple memory-mapped read/write port. The base location is cleared, a fixed signature word is written at a power-of-two offset from the base, and both locations are read back. If the memory does not decode the probed address bit, the write folds onto the base and the base no longer reads zero.

Candidates are tried from the largest downwards, so the first passing candidate is the real size. Columns are probed first, then rows, then a second rank. The data bus width (16 or 32 bits) is supplied by the caller, because it shifts the column probe offsets. A one-cycle done pulse marks the end of the run. The results then hold until the next start.

Top module: `geo_probe`

## Requirements
- R1: After reset the engine is idle: busy_o, done_o, mem_req_o, both error flags and all result outputs are 0.
- R2: Every probe first writes 0 to the base address (BASE_ADDR, default 0) and then writes the signature 32'h5AA5F00F at the probe address. The only data words the engine ever writes are 0, the signature and its bitwise complement, so the number of zero writes to the base equals the number of probes.
- R3: Column candidates are 11, 10 and 9 in that order. Candidate c probes base + (1 << (c + w - 1)), where w = 2 when bus32_i = 1 and w = 1 when bus32_i = 0. col_bits_o reports the first passing candidate.
- R4: A probe passes only if the read of the probe address returns the signature and the later read of the base returns 0.
- R5: If no column candidate passes, col_err_o = 1, no row or rank probe is made (exactly 3 probes in total), and row_bits_o, ranks_o and row_err_o stay 0.
- R6: Row candidates are 16 down to 12. Candidate r probes base + (1 << (r + 13)). row_bits_o reports the first passing candidate, which is taken for both ranks.
- R7: If no row candidate passes, row_err_o = 1 and row_bits_o = 0, and rank detection still runs.
- R8: The rank probe writes the signature at base + (1 << 30) and its complement at base + (1 << 30) + 4, exactly once per run. ranks_o = 2 if the probe passes, else 1.
- R9: A request (mem_req_o with address, write enable and data) stays asserted and unchanged until mem_ready_i. After an accepted read, no new request is issued until mem_rvalid_i returns the data.
- R10: done_o is a single-cycle pulse in the cycle busy_o falls. Results hold until the next accepted start, and start_i while busy_o is high is ignored (the bus width of the running probe is kept).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a probe run (taken only while idle) |
| bus32_i | input | 1 | 1: 32-bit data bus, 0: 16-bit data bus |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | 1: write, 0: read |
| mem_addr_o | output | AW (32) | Byte address |
| mem_wdata_o | output | DW (32) | Write data |
| mem_ready_i | input | 1 | Request accepted this cycle |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | DW (32) | Read data |
| busy_o | output | 1 | Probe run in progress |
| done_o | output | 1 | One-cycle pulse at end of run |
| col_bits_o | output | CW (5) | Detected column bits (0 on error) |
| row_bits_o | output | CW (5) | Detected row bits (0 on error) |
| ranks_o | output | 2 | Detected rank count (0 after a column error) |
| col_err_o | output | 1 | No column candidate passed |
| row_err_o | output | 1 | No row candidate passed |

## Verification
The assertions assume a well-behaved memory side: mem_rvalid_i is raised only once for each accepted read, and only after that read. mem_ready_i is meaningful only while a request is pending. The bench responder holds to this by driving ready at random only while a request is pending and no read is outstanding, and by returning each read after a random latency of one to three cycles. The memory model emulates geometry by masking out undecoded address bits, so that unimplemented column, row and rank bits fold onto lower addresses. Configurations with too few column or row bits drive the error paths.

// File: rtl/geo_probe_pkg.sv
package geo_probe_pkg;
  typedef enum logic [1:0] {PH_COL, PH_ROW, PH_RANK} phase_e;
  typedef enum logic [2:0] {
    OP_CLR_BASE,
    OP_SET_PAT,
    OP_SET_INV,
    OP_GET_OFF,
    OP_GET_BASE
  } op_e;
  localparam logic [31:0] SIGNATURE = 32'h5AA5_F00F;
endpackage

// File: rtl/geo_offset.sv
module geo_offset
  import geo_probe_pkg::*;
#(
  parameter int              AW        = 32,
  parameter int              CW        = 5,
  parameter int              ROW_GAP   = 13,
  parameter int              RANK_BIT  = 30,
  parameter logic [AW-1:0]   BASE_ADDR = '0
) (
  input  phase_e          phase_i,
  input  logic [CW-1:0]   cand_i,
  input  logic            bus32_i,
  input  op_e             op_i,
  output logic [AW-1:0]   addr_o
);
  localparam int SW = $clog2(AW);

  logic [SW-1:0] sh;
  logic [AW-1:0] off;

  always_comb begin
    case (phase_i)
      PH_COL:  sh = SW'(cand_i) + SW'(bus32_i);   // col + w - 1
      PH_ROW:  sh = SW'(cand_i) + SW'(ROW_GAP);
      default: sh = SW'(RANK_BIT);
    endcase
    off = AW'(1) << sh;
    if (op_i == OP_SET_INV) off = off + AW'(4);
    if (op_i == OP_CLR_BASE || op_i == OP_GET_BASE) addr_o = BASE_ADDR;
    else                                            addr_o = BASE_ADDR + off;
  end
endmodule

// File: rtl/geo_bus.sv
module geo_bus #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ack_o,
  output logic [DW-1:0] rdata_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ready_i,
  input  logic          mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i
);
  typedef enum logic [1:0] {B_IDLE, B_REQ, B_RESP} bst_e;

  bst_e          st_q;
  logic          we_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= B_IDLE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      case (st_q)
        B_IDLE: if (go_i) begin
          st_q    <= B_REQ;
          we_q    <= we_i;
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
        end
        B_REQ: if (mem_ready_i) st_q <= we_q ? B_IDLE : B_RESP;
        B_RESP: if (mem_rvalid_i) st_q <= B_IDLE;
        default: st_q <= B_IDLE;
      endcase
    end
  end

  assign mem_req_o   = (st_q == B_REQ);
  assign mem_we_o    = we_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
  assign ack_o       = (st_q == B_REQ && mem_ready_i && we_q) ||
                       (st_q == B_RESP && mem_rvalid_i);
  assign rdata_o     = mem_rdata_i;
endmodule

// File: rtl/geo_seq.sv
module geo_seq
  import geo_probe_pkg::*;
#(
  parameter int DW     = 32,
  parameter int CW     = 5,
  parameter int COL_HI = 11,
  parameter int COL_LO = 9,
  parameter int ROW_HI = 16,
  parameter int ROW_LO = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          bus32_i,
  input  logic          ack_i,
  input  logic [DW-1:0] rdata_i,
  output logic          go_o,
  output logic          we_o,
  output logic [DW-1:0] wdata_o,
  output op_e           op_o,
  output phase_e        phase_o,
  output logic [CW-1:0] cand_o,
  output logic          bus32_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [CW-1:0] col_o,
  output logic [CW-1:0] row_o,
  output logic [1:0]    ranks_o,
  output logic          col_err_o,
  output logic          row_err_o
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_EVAL} st_e;

  localparam logic [DW-1:0] SIG = DW'(SIGNATURE);

  st_e           st_q;
  phase_e        phase_q;
  op_e           op_q, op_nxt;
  logic [CW-1:0] cand_q, col_q, row_q;
  logic [1:0]    ranks_q;
  logic          bus32_q, done_q, col_err_q, row_err_q;
  logic [DW-1:0] rd_off_q, rd_base_q;
  logic          pass;

  always_comb begin
    case (op_q)
      OP_CLR_BASE: op_nxt = OP_SET_PAT;
      OP_SET_PAT:  op_nxt = (phase_q == PH_RANK) ? OP_SET_INV : OP_GET_OFF;
      OP_SET_INV:  op_nxt = OP_GET_OFF;
      default:     op_nxt = OP_GET_BASE;
    endcase
  end

  assign pass = (rd_off_q == SIG) && (rd_base_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      phase_q   <= PH_COL;
      op_q      <= OP_CLR_BASE;
      cand_q    <= '0;
      bus32_q   <= 1'b0;
      col_q     <= '0;
      row_q     <= '0;
      ranks_q   <= '0;
      col_err_q <= 1'b0;
      row_err_q <= 1'b0;
      done_q    <= 1'b0;
      rd_off_q  <= '0;
      rd_base_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        S_IDLE: if (start_i) begin
          st_q      <= S_ISSUE;
          phase_q   <= PH_COL;
          op_q      <= OP_CLR_BASE;
          cand_q    <= CW'(COL_HI);
          bus32_q   <= bus32_i;
          col_q     <= '0;
          row_q     <= '0;
          ranks_q   <= '0;
          col_err_q <= 1'b0;
          row_err_q <= 1'b0;
        end
        S_ISSUE: st_q <= S_WAIT;
        S_WAIT: if (ack_i) begin
          if (op_q == OP_GET_OFF) rd_off_q <= rdata_i;
          if (op_q == OP_GET_BASE) begin
            rd_base_q <= rdata_i;
            st_q      <= S_EVAL;
          end else begin
            op_q <= op_nxt;
            st_q <= S_ISSUE;
          end
        end
        S_EVAL: begin
          op_q <= OP_CLR_BASE;
          st_q <= S_ISSUE;
          case (phase_q)
            PH_COL: begin
              if (pass) begin
                col_q   <= cand_q;
                phase_q <= PH_ROW;
                cand_q  <= CW'(ROW_HI);
              end else if (cand_q == CW'(COL_LO)) begin
                col_err_q <= 1'b1;
                st_q      <= S_IDLE;
                done_q    <= 1'b1;
              end else begin
                cand_q <= cand_q - 1'b1;
              end
            end
            PH_ROW: begin
              if (pass) begin
                row_q   <= cand_q;
                phase_q <= PH_RANK;
              end else if (cand_q == CW'(ROW_LO)) begin
                row_err_q <= 1'b1;
                phase_q   <= PH_RANK;
              end else begin
                cand_q <= cand_q - 1'b1;
              end
            end
            default: begin
              ranks_q <= pass ? 2'd2 : 2'd1;
              st_q    <= S_IDLE;
              done_q  <= 1'b1;
            end
          endcase
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (op_q)
      OP_SET_PAT: wdata_o = SIG;
      OP_SET_INV: wdata_o = ~SIG;
      default:    wdata_o = '0;
    endcase
  end

  assign go_o      = (st_q == S_ISSUE);
  assign we_o      = (op_q == OP_CLR_BASE) || (op_q == OP_SET_PAT) || (op_q == OP_SET_INV);
  assign op_o      = op_q;
  assign phase_o   = phase_q;
  assign cand_o    = cand_q;
  assign bus32_o   = bus32_q;
  assign busy_o    = (st_q != S_IDLE);
  assign done_o    = done_q;
  assign col_o     = col_q;
  assign row_o     = row_q;
  assign ranks_o   = ranks_q;
  assign col_err_o = col_err_q;
  assign row_err_o = row_err_q;
endmodule

// File: rtl/geo_probe.sv
module geo_probe
  import geo_probe_pkg::*;
#(
  parameter int            AW        = 32,
  parameter int            DW        = 32,
  parameter int            CW        = 5,
  parameter int            COL_HI    = 11,
  parameter int            COL_LO    = 9,
  parameter int            ROW_HI    = 16,
  parameter int            ROW_LO    = 12,
  parameter int            ROW_GAP   = 13,
  parameter int            RANK_BIT  = 30,
  parameter logic [AW-1:0] BASE_ADDR = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          bus32_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ready_i,
  input  logic          mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [CW-1:0] col_bits_o,
  output logic [CW-1:0] row_bits_o,
  output logic [1:0]    ranks_o,
  output logic          col_err_o,
  output logic          row_err_o
);
  logic          go, we, ack, bus32_run;
  logic [DW-1:0] wdata, rdata;
  logic [AW-1:0] addr;
  logic [CW-1:0] cand;
  op_e           op;
  phase_e        phase;

  geo_seq #(
    .DW(DW), .CW(CW), .COL_HI(COL_HI), .COL_LO(COL_LO),
    .ROW_HI(ROW_HI), .ROW_LO(ROW_LO)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .bus32_i   (bus32_i),
    .ack_i     (ack),
    .rdata_i   (rdata),
    .go_o      (go),
    .we_o      (we),
    .wdata_o   (wdata),
    .op_o      (op),
    .phase_o   (phase),
    .cand_o    (cand),
    .bus32_o   (bus32_run),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .col_o     (col_bits_o),
    .row_o     (row_bits_o),
    .ranks_o   (ranks_o),
    .col_err_o (col_err_o),
    .row_err_o (row_err_o)
  );

  geo_offset #(
    .AW(AW), .CW(CW), .ROW_GAP(ROW_GAP), .RANK_BIT(RANK_BIT), .BASE_ADDR(BASE_ADDR)
  ) u_off (
    .phase_i (phase),
    .cand_i  (cand),
    .bus32_i (bus32_run),
    .op_i    (op),
    .addr_o  (addr)
  );

  geo_bus #(.AW(AW), .DW(DW)) u_bus (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .go_i         (go),
    .we_i         (we),
    .addr_i       (addr),
    .wdata_i      (wdata),
    .ack_o        (ack),
    .rdata_o      (rdata),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_ready_i  (mem_ready_i),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i)
  );
endmodule

// File: rtl/geo_probe_chk.sv
module geo_probe_chk #(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int CW     = 5,
  parameter int COL_HI = 11,
  parameter int COL_LO = 9,
  parameter int ROW_HI = 16,
  parameter int ROW_LO = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          mem_ready_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [CW-1:0] col_bits_o,
  input logic [CW-1:0] row_bits_o,
  input logic [1:0]    ranks_o,
  input logic          col_err_o,
  input logic          row_err_o
);
  localparam logic [DW-1:0] SIG = DW'(32'h5AA5_F00F);

  a_r1_idle_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);

  a_r9_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) &&
                                  $stable(mem_we_o) && $stable(mem_wdata_o));

  a_r2_write_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> (mem_wdata_o == '0) || (mem_wdata_o == SIG) ||
                              (mem_wdata_o == ~SIG));

  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(col_bits_o) && $stable(row_bits_o) &&
                            $stable(ranks_o) && $stable(col_err_o) && $stable(row_err_o));

  a_r5_col_err_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && col_err_o |-> ranks_o == 2'd0 && row_bits_o == '0 && !row_err_o &&
                            col_bits_o == '0);

  a_r3_col_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !col_err_o |-> col_bits_o >= CW'(COL_LO) && col_bits_o <= CW'(COL_HI));

  a_r6_row_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !col_err_o && !row_err_o |-> row_bits_o >= CW'(ROW_LO) &&
                                           row_bits_o <= CW'(ROW_HI));

  a_r7_row_err_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && row_err_o |-> row_bits_o == '0);

  a_r8_rank_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !col_err_o |-> ranks_o == 2'd1 || ranks_o == 2'd2);
endmodule

bind geo_probe geo_probe_chk #(
  .AW(AW), .DW(DW), .CW(CW), .COL_HI(COL_HI), .COL_LO(COL_LO),
  .ROW_HI(ROW_HI), .ROW_LO(ROW_LO)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ready_i (mem_ready_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .col_bits_o  (col_bits_o),
  .row_bits_o  (row_bits_o),
  .ranks_o     (ranks_o),
  .col_err_o   (col_err_o),
  .row_err_o   (row_err_o)
);

// File: tb/geo_probe_tb_top.sv
`timescale 1ns/1ps
module geo_probe_tb_top;
  localparam logic [31:0] SIG = 32'h5AA5_F00F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        bus32 = 1'b0;
  logic        mem_req, mem_we, mem_ready, mem_rvalid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        busy, done, col_err, row_err;
  logic [4:0]  col_bits, row_bits;
  logic [1:0]  ranks;

  always #4 clk = ~clk;

  geo_probe dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .bus32_i(bus32),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .busy_o(busy), .done_o(done),
    .col_bits_o(col_bits), .row_bits_o(row_bits), .ranks_o(ranks),
    .col_err_o(col_err), .row_err_o(row_err)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  // memory model state
  logic [31:0] mem [logic [31:0]];
  logic [31:0] m_mask = '0;
  int zero_base_wr = 0;
  int inv_wr = 0;
  int bad_wr = 0;
  int req_in_flight = 0;
  bit pend = 0;
  int lat = 0;
  logic [31:0] rd_hold = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] geo_mask(int c, int r, int k, bit b32);
    longint m;
    int w = b32 ? 2 : 1;
    m = (64'd1 << (c + w)) - 1;
    m = m | (((64'd1 << (r + 14)) - 1) & ~((64'd1 << 14) - 1));
    if (k == 2) m = m | (64'd1 << 30);
    return m[31:0];
  endfunction

  // memory responder
  initial begin
    mem_ready = 0; mem_rvalid = 0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_rvalid = 0;
      if (pend) begin
        if (lat == 0) begin
          mem_rvalid = 1; mem_rdata = rd_hold; pend = 0;
        end else lat--;
      end
      if (pend && mem_req) req_in_flight++;
      mem_ready = 0;
      if (mem_req && !pend && !mem_rvalid && ($urandom % 4 != 0)) begin
        mem_ready = 1;
        if (mem_we) begin
          mem[mem_addr & m_mask] = mem_wdata;
          if (mem_addr == 32'd0 && mem_wdata == 32'd0) zero_base_wr++;
          if (mem_addr == 32'h4000_0004 && mem_wdata == ~SIG) inv_wr++;
          if (mem_wdata != 0 && mem_wdata != SIG && mem_wdata != ~SIG) bad_wr++;
        end else begin
          rd_hold = mem.exists(mem_addr & m_mask) ? mem[mem_addr & m_mask] : 32'hDEAD_BEEF;
          pend = 1;
          lat = $urandom % 3;
        end
      end
    end
  end

  task automatic run_case(input int c, input int r, input int k, input bit b32, input bit poke);
    int ec, er, ek, ecerr, ererr, probes, wait_n;
    logic [4:0] h_col, h_row;
    logic [1:0] h_rk;
    mem.delete();
    m_mask = geo_mask(c, r, k, b32);
    zero_base_wr = 0; inv_wr = 0; bad_wr = 0; req_in_flight = 0;
    ecerr = (c < 9);
    ec    = ecerr ? 0 : c;
    ererr = !ecerr && (r < 12);
    er    = (ecerr || ererr) ? 0 : r;
    ek    = ecerr ? 0 : (k == 2 ? 2 : 1);
    probes = ecerr ? 3 : (11 - c + 1) + (r >= 12 ? 16 - r + 1 : 5) + 1;
    @(negedge clk); start = 1; bus32 = b32;
    @(negedge clk); start = 0;
    if (poke) begin
      repeat (5) @(negedge clk);
      start = 1; bus32 = !b32;
      @(negedge clk); start = 0;
    end
    wait_n = 0;
    while (!done && wait_n < 20000) begin @(negedge clk); wait_n++; end
    chk("R10 done seen", {31'd0, done}, 32'd1);
    chk("R10 busy low at done", {31'd0, busy}, 32'd0);
    chk("R3 col_bits", {27'd0, col_bits}, ec);
    chk("R5 col_err", {31'd0, col_err}, ecerr);
    chk("R6 row_bits", {27'd0, row_bits}, er);
    chk("R7 row_err", {31'd0, row_err}, ererr);
    chk("R8 ranks", {30'd0, ranks}, ek);
    chk("R2 probe count", zero_base_wr, probes);
    chk("R2 write data set", bad_wr, 0);
    chk("R8 complement write", inv_wr, ecerr ? 0 : 1);
    chk("R9 no request while read pending", req_in_flight, 0);
    h_col = col_bits; h_row = row_bits; h_rk = ranks;
    repeat (3) @(negedge clk);
    chk("R10 done one cycle", {31'd0, done}, 32'd0);
    chk("R10 results hold", {20'd0, h_col, h_row, h_rk}, {20'd0, col_bits, row_bits, ranks});
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired R10 actual=busy expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 busy after reset", {31'd0, busy}, 0);
    chk("R1 done after reset", {31'd0, done}, 0);
    chk("R1 req after reset", {31'd0, mem_req}, 0);
    chk("R1 results after reset", {18'd0, col_bits, row_bits, ranks, col_err, row_err}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1 idle after release", {30'd0, busy, mem_req}, 0);
    // directed corners
    run_case(11, 16, 2, 1'b1, 1'b0);   // R3 R6 R8 largest
    run_case(9, 12, 1, 1'b0, 1'b0);    // R3 R6 smallest, 16-bit bus
    run_case(8, 14, 2, 1'b1, 1'b0);    // R5 column error
    run_case(10, 11, 2, 1'b0, 1'b0);   // R7 row error, rank still probed
    run_case(10, 14, 2, 1'b1, 1'b1);   // R10 start while busy ignored
    run_case(11, 13, 1, 1'b0, 1'b0);   // R4 single rank folds onto base
    for (int i = 0; i < 10; i++) begin
      run_case(8 + ($urandom % 4), 11 + ($urandom % 6), 1 + ($urandom % 2),
               1'($urandom % 2), 1'b0);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule